// File: doc/BRIEF.md
# Power-Management Event Register Block

This block holds the event registers of a power-management controller that is mapped into I/O space. Each hardware event arrives as a single-cycle pulse and latches a sticky status bit. Software reads the status bits one byte at a time and clears them by writing ones. Each status bit that has an enable partner can raise the system control interrupt (SCI), a level output. The SCI is asserted while any pending status bit is also enabled and the global SCI gate in the control register is on.

The block takes an eight-byte window of I/O space. The window starts at a base address that the configuration logic supplies on a 16-bit input, and changing that input moves the whole block. The byte offsets are:

- Offsets 0 and 1: status, low byte then high byte.
- Offsets 2 and 3: enable, low byte then high byte.
- Offset 4: control.
- Offsets 5 to 7: read as zero.

The implemented bits are:

- Status low byte: timer event at bit 0, bus-master activity at bit 4 and global event at bit 5.
- Status high byte: a wake event at bit 8.
- Enable: the timer, global and wake bits have enable partners. The bus-master bit has none and is status-only.

Top module: `pm_event_block`

## Requirements
- R1: An access is decoded only when `io_addr - base_addr` lies in 0..7. Writes outside that window change nothing, and reads outside it return 00h. Changing `base_addr` moves the window.
- R2: A status bit is set only by a pulse on its `evt_pulse` line. A software write of any value never sets a status bit.
- R3: Writing 1 to an implemented status bit (offset 0 for bits 7:0, offset 1 for bits 15:8) clears it. Writing 0 leaves it unchanged.
- R4: When an event pulse and a write-one-clear hit the same status bit in the same cycle, the bit ends set.
- R5: `sci` is a register that equals the control bit 0 ANDed with the OR of (status AND enable). It reflects each register change on the same clock edge.
- R6: Status bit 4 (bus master) has no enable bit. Enable bit 4 reads 0, ignores writes, and bit 4 never causes `sci`.
- R7: Status implements only bits 0, 4, 5 and 8. Enable implements only bits 0, 5 and 8. All other bits read 0 and ignore writes and event pulses.
- R8: The control register at offset 4 implements only bit 0 (the global SCI gate), and its other bits read 0. Offsets 5 to 7 read 00h and ignore writes.
- R9: After reset, status, enable and control are 0 and `sci` is low. `io_rdata` is 00h whenever `io_rd` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| base_addr | input | 16 | I/O base address of the block |
| io_addr | input | 16 | I/O byte address |
| io_wr | input | 1 | Write strobe, one cycle per byte |
| io_rd | input | 1 | Read strobe |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data (combinational) |
| evt_pulse | input | 16 | Hardware event pulses, one bit per status position |
| sci | output | 1 | System control interrupt, active-high level |

## Verification
The assertions assume two things about the inputs:

- `io_wr` and `io_rd` are never asserted together.
- `evt_pulse` lines are one-cycle strobes. Only the write-one-clear check relies on this, through its exclusion of bits with a pulse in the same cycle.

The directed stimulus meets both assumptions. Every access is a single strobe cycle driven on the falling edge. Every event is raised for exactly one cycle, and a pulse is combined with a clear write only in the priority test.

// File: rtl/pm_event_block.sv
module pm_event_block #(
  parameter int          AW       = 16,
  parameter int          SPAN_LOG = 3,
  parameter logic [15:0] STS_MASK = 16'h0131,
  parameter logic [15:0] EN_MASK  = 16'h0121
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] base_addr,
  input  logic [AW-1:0] io_addr,
  input  logic          io_wr,
  input  logic          io_rd,
  input  logic [7:0]    io_wdata,
  output logic [7:0]    io_rdata,
  input  logic [15:0]   evt_pulse,
  output logic          sci
);
  logic [AW-1:0] off;
  logic          hit;
  logic [15:0]   sts, en, clr, sts_n, en_n;
  logic          gate, gate_n;

  assign off = io_addr - base_addr;
  assign hit = (off >> SPAN_LOG) == '0;

  wire wr_s0 = io_wr && hit && off[SPAN_LOG-1:0] == 0;
  wire wr_s1 = io_wr && hit && off[SPAN_LOG-1:0] == 1;
  wire wr_e0 = io_wr && hit && off[SPAN_LOG-1:0] == 2;
  wire wr_e1 = io_wr && hit && off[SPAN_LOG-1:0] == 3;
  wire wr_c  = io_wr && hit && off[SPAN_LOG-1:0] == 4;

  assign clr   = {wr_s1 ? io_wdata : 8'h00, wr_s0 ? io_wdata : 8'h00} & STS_MASK;
  assign sts_n = ((sts & ~clr) | evt_pulse) & STS_MASK;
  assign en_n  = {wr_e1 ? io_wdata : en[15:8], wr_e0 ? io_wdata : en[7:0]} & EN_MASK;
  assign gate_n = wr_c ? io_wdata[0] : gate;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sts  <= '0;
      en   <= '0;
      gate <= 1'b0;
      sci  <= 1'b0;
    end else begin
      sts  <= sts_n;
      en   <= en_n;
      gate <= gate_n;
      sci  <= gate_n && |(sts_n & en_n);
    end
  end

  always_comb begin
    io_rdata = 8'h00;
    if (io_rd && hit) begin
      case (off[SPAN_LOG-1:0])
        0:       io_rdata = sts[7:0];
        1:       io_rdata = sts[15:8];
        2:       io_rdata = en[7:0];
        3:       io_rdata = en[15:8];
        4:       io_rdata = {7'b0, gate};
        default: io_rdata = 8'h00;
      endcase
    end
  end

  AST_NO_SW_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (sts & ~$past(sts) & ~$past(evt_pulse)) == 16'h0); // R2
  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (clr & ~evt_pulse) != 16'h0 |=> (sts & $past(clr & ~evt_pulse)) == 16'h0); // R3
  AST_EVT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_pulse & STS_MASK) != 16'h0 |=> (sts & $past(evt_pulse & STS_MASK)) == $past(evt_pulse & STS_MASK)); // R4
  AST_SCI_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    sci |-> gate && (sts & en) != 16'h0); // R5
  AST_SCI_PRESENT: assert property (@(posedge clk) disable iff (!rst_n)
    (gate && (sts & en) != 16'h0) |-> sci); // R5
  AST_RSV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (sts & ~STS_MASK) == 16'h0 && (en & ~EN_MASK) == 16'h0); // R7
  AST_RD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !io_rd |-> io_rdata == 8'h00); // R9
endmodule

// File: tb/pm_event_block_test.sv
module pm_event_block_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] base_addr = 16'h0840;
  logic [15:0] io_addr = '0;
  logic        io_wr = 1'b0, io_rd = 1'b0;
  logic [7:0]  io_wdata = '0;
  logic [7:0]  io_rdata;
  logic [15:0] evt_pulse = '0;
  logic        sci;
  int          n_vec = 0, n_bad = 0;

  pm_event_block uut (.clk(clk), .rst_n(rst_n), .base_addr(base_addr), .io_addr(io_addr),
    .io_wr(io_wr), .io_rd(io_rd), .io_wdata(io_wdata), .io_rdata(io_rdata),
    .evt_pulse(evt_pulse), .sci(sci));

  always #10 clk = ~clk;

  task automatic chk(string req, logic [7:0] got, logic [7:0] exp);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%02h exp=%02h", req, got, exp);
    end
  endtask

  task automatic wr_abs(logic [15:0] a, logic [7:0] d);
    @(negedge clk); io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(negedge clk); io_wr = 1'b0;
  endtask

  task automatic wr(int o, logic [7:0] d);
    wr_abs(base_addr + 16'(o), d);
  endtask

  task automatic rd_abs(logic [15:0] a, output logic [7:0] d);
    @(negedge clk); io_addr = a; io_rd = 1'b1;
    #1 d = io_rdata;
    io_rd = 1'b0;
  endtask

  task automatic rd_chk(string req, int o, logic [7:0] exp);
    logic [7:0] d;
    rd_abs(base_addr + 16'(o), d);
    chk(req, d, exp);
  endtask

  task automatic pulse(logic [15:0] e);
    @(negedge clk); evt_pulse = e;
    @(negedge clk); evt_pulse = '0;
  endtask

  task automatic t_reset;
    for (int o = 0; o < 8; o++) rd_chk("R9", o, 8'h00);
    chk("R9 sci", {7'b0, sci}, 8'h00);
    @(negedge clk); io_addr = base_addr;
    #1 chk("R9 rd idle", io_rdata, 8'h00);
  endtask

  task automatic t_latch;
    pulse(16'hFFFF);
    rd_chk("R7 sts lo", 0, 8'h31);
    rd_chk("R7 sts hi", 1, 8'h01);
    chk("R5 no en", {7'b0, sci}, 8'h00);
  endtask

  task automatic t_w1c;
    wr(0, 8'h00);
    rd_chk("R3 zero no effect", 0, 8'h31);
    wr(0, 8'h01);
    rd_chk("R3 clear bit0", 0, 8'h30);
    wr(1, 8'hFF);
    rd_chk("R3 clear hi", 1, 8'h00);
    wr(0, 8'hFF);
    rd_chk("R3 clear all", 0, 8'h00);
    wr(0, 8'hFF); wr(1, 8'hFF);
    rd_chk("R2 no sw set lo", 0, 8'h00);
    rd_chk("R2 no sw set hi", 1, 8'h00);
  endtask

  task automatic t_enable;
    wr(2, 8'hFF);
    rd_chk("R6 en lo", 2, 8'h21);
    wr(3, 8'hFF);
    rd_chk("R7 en hi", 3, 8'h01);
  endtask

  task automatic t_sci;
    wr(4, 8'hFF);
    rd_chk("R8 ctl", 4, 8'h01);
    pulse(16'h0010);
    rd_chk("R6 bm sts", 0, 8'h10);
    chk("R6 bm no sci", {7'b0, sci}, 8'h00);
    pulse(16'h0001);
    chk("R5 sci set", {7'b0, sci}, 8'h01);
    wr(2, 8'h00);
    chk("R5 en off", {7'b0, sci}, 8'h00);
    wr(2, 8'h21);
    chk("R5 en on", {7'b0, sci}, 8'h01);
    wr(4, 8'h00);
    chk("R5 gate off", {7'b0, sci}, 8'h00);
    wr(4, 8'h01);
    chk("R5 gate on", {7'b0, sci}, 8'h01);
    wr(0, 8'h01);
    chk("R5 w1c drops sci", {7'b0, sci}, 8'h00);
    rd_chk("R3 bm kept", 0, 8'h10);
    pulse(16'h0100);
    chk("R5 hi bit sci", {7'b0, sci}, 8'h01);
    wr(1, 8'h01);
    chk("R5 hi clear", {7'b0, sci}, 8'h00);
  endtask

  task automatic t_priority;
    @(negedge clk);
    io_addr = base_addr; io_wdata = 8'h20; io_wr = 1'b1; evt_pulse = 16'h0020;
    @(negedge clk); io_wr = 1'b0; evt_pulse = '0;
    rd_chk("R4 event wins", 0, 8'h30);
    chk("R4 sci", {7'b0, sci}, 8'h01);
    wr(0, 8'hFF);
    rd_chk("R4 cleared later", 0, 8'h00);
  endtask

  task automatic t_decode;
    logic [7:0] d;
    for (int o = 5; o < 8; o++) begin
      wr(o, 8'hFF);
      rd_chk("R8 hole", o, 8'h00);
    end
    wr_abs(base_addr + 16'd10, 8'hFF);
    wr_abs(base_addr - 16'd2, 8'hFF);
    rd_chk("R1 en unchanged", 2, 8'h21);
    rd_chk("R1 ctl unchanged", 4, 8'h01);
    pulse(16'h0001);
    rd_abs(base_addr + 16'd8, d); chk("R1 out rd", d, 8'h00);
    base_addr = 16'h0900;
    rd_abs(16'h0840, d); chk("R1 old base", d, 8'h00);
    rd_chk("R1 new base", 0, 8'h01);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_latch;
    t_w1c;
    t_enable;
    t_sci;
    t_priority;
    t_decode;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #4000000;
    n_vec++; n_bad++;
    $display("FAIL watchdog got=hang exp=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule